// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Memory

A synchronous single-port memory of 16-bit words, each split into two byte lanes. Each lane is kept as its own 13-bit codeword: eight data bits and five check bits. The check bits form a single-error-correcting, double-error-detecting code made of a Hamming(12,8) code and one overall parity bit. A write encodes only the lanes it enables. A read decodes both lanes on their own. The results of the lanes that are presented are merged into two word-level flags: one for a corrected single-bit error and one for an uncorrectable error.

Control follows an asynchronous-SRAM style truth table, mapped onto a clock with active-high signals. A selected cycle with `wr_en` high is a write. A selected cycle with `wr_en` low is a read. For each lane, data is presented only when output enable and that lane's enable are both high. Tri-state pins are not modelled. Instead, a per-lane drive signal says which lanes carry data, and data and flags are zero wherever nothing is driven.

Read results appear one clock after the read cycle. A test port XORs a 13-bit mask into any stored codeword, so that single-bit and double-bit faults can be exercised in each lane.

Top module: `bsd_mem`

## Requirements
- R1: A write with both lanes enabled, followed by a read with output enable and both lanes enabled, returns the written word on `rdata` in the cycle after the read, with `rdata_drv` = 2'b11 and both flags low.
- R2: A write stores lane 0 (`wdata[7:0]`, enabled by `lane_en[0]`) and lane 1 (`wdata[15:8]`, enabled by `lane_en[1]`) only when that lane's enable is high. A disabled lane keeps its data and its check bits, including any fault already present in them.
- R3: On a read, `rdata_drv[i]` is high exactly when both `rd_oe` and `lane_en[i]` are high, and lane i of `rdata` then carries that lane's decoded data.
- R4: A lane that is not driven shows zero data. When `sel` is low, in a write cycle, or when `rd_oe` is low, the next cycle shows `rdata_drv` = 0, `rdata` = 0 and both flags low.
- R5: A fault in any one of the 13 stored bits of a lane is corrected on read, and `err_corr` is raised with `err_unc` low.
- R6: Any two faulty bits within one lane raise `err_unc`, and that lane is never reported as corrected. When `err_unc` is high, the read data is not valid.
- R7: A single-bit fault in one lane together with a double-bit fault in the other raises `err_corr` and `err_unc` in the same cycle.
- R8: The flags take into account only the lanes being presented: a faulty lane whose output is not enabled raises no flag.
- R9: Injection XORs `inj_mask` into the codeword of lane `inj_lane` at `inj_addr`. The fault persists across reads until that lane is written again, and injecting the same mask twice restores the codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read-output registers |
| sel | input | 1 | Chip select; high starts an access |
| wr_en | input | 1 | High selects a write, low a read |
| rd_oe | input | 1 | Output enable for reads |
| lane_en | input | 2 | Byte-lane enables; bit 0 is the low byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| inj_en | input | 1 | Apply a fault mask this cycle |
| inj_lane | input | 1 | Lane receiving the fault mask |
| inj_addr | input | ADDR_W | Word receiving the fault mask |
| inj_mask | input | 13 | Bits to flip in the stored codeword |
| rdata | output | 16 | Read data, zero in lanes that are not driven |
| rdata_drv | output | 2 | Per-lane data-valid (stands in for output enable) |
| err_corr | output | 1 | A presented lane had a corrected single-bit error |
| err_unc | output | 1 | A presented lane had an uncorrectable error |

## Verification
On every cycle, the assertions check three things. A lane is never driven without both its enable and output enable in the previous cycle. Nothing is driven after a write or while deselected. Undriven lanes show zero and flags never rise without a driven lane. They also check that no lane's decoder reports correction and failure together.

Only the bench's scenarios can show that decoding is correct. It sweeps every single-bit position and every pair of positions in both lanes, and checks lane-selective writes that keep an existing fault. It also covers the mixed-flag case and the persistence and cancellation of injected faults.

// File: rtl/bsd_mem_pkg.sv
package bsd_mem_pkg;
    localparam int BYTE_W = 8;
    localparam int CW_W   = 13;
    localparam int LANES  = 2;
    localparam int WORD_W = LANES * BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic [LANES-1:0]  drv;
        logic              corr;
        logic              unc;
    } rd_out_t;

    // Hamming positions 1..12 live in cw[12:1]; cw[0] is overall parity.
    function automatic logic [CW_W-1:0] secded_encode(input logic [BYTE_W-1:0] d);
        logic [12:1] h;
        logic        x;
        int          k;
        h = '0;
        k = 0;
        for (int p = 1; p <= 12; p++) begin
            if ((p & (p - 1)) != 0) begin
                h[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 4; b++) begin
            x = 1'b0;
            for (int p = 1; p <= 12; p++) begin
                if (((p >> b) & 1) == 1 && p != (1 << b)) x = x ^ h[p];
            end
            h[1 << b] = x;
        end
        return {h, ^h};
    endfunction
endpackage

// File: rtl/secded_lane_enc.sv
module secded_lane_enc
    import bsd_mem_pkg::*;
(
    input  logic [BYTE_W-1:0] data_in,
    output logic [CW_W-1:0]   cw_out
);
    assign cw_out = secded_encode(data_in);
endmodule

// File: rtl/secded_lane_dec.sv
module secded_lane_dec
    import bsd_mem_pkg::*;
(
    input  logic [CW_W-1:0]   cw_in,
    output logic [BYTE_W-1:0] data_out,
    output logic              corr,
    output logic              unc
);
    logic [12:1] fix;
    logic [3:0]  syn;
    logic        par_err;
    int          k;

    always_comb begin
        fix     = cw_in[12:1];
        syn     = '0;
        par_err = ^cw_in;
        corr    = 1'b0;
        unc     = 1'b0;
        for (int p = 1; p <= 12; p++) begin
            if (cw_in[p]) syn = syn ^ p[3:0];
        end
        if (par_err) begin
            // zero syndrome: the overall parity bit itself flipped
            corr = 1'b1;
            if (syn > 4'd12) begin
                corr = 1'b0;
                unc  = 1'b1;
            end else begin
                for (int p = 1; p <= 12; p++) begin
                    if (syn == p[3:0]) fix[p] = ~fix[p];
                end
            end
        end else if (syn != 4'd0) begin
            unc = 1'b1;
        end
        data_out = '0;
        k = 0;
        for (int p = 1; p <= 12; p++) begin
            if ((p & (p - 1)) != 0) begin
                data_out[k] = fix[p];
                k++;
            end
        end
    end
endmodule

// File: rtl/bsd_mem.sv
module bsd_mem
    import bsd_mem_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_oe,
    input  logic [1:0]        lane_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              inj_en,
    input  logic              inj_lane,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [12:0]       inj_mask,
    output logic [15:0]       rdata,
    output logic [1:0]        rdata_drv,
    output logic              err_corr,
    output logic              err_unc
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              do_write;
    logic              do_read;
    logic [BYTE_W-1:0] dec_data [LANES];
    logic [LANES-1:0]  dec_corr;
    logic [LANES-1:0]  dec_unc;
    rd_out_t           out_d, out_q;

    assign do_write = sel && wr_en;
    assign do_read  = sel && !wr_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW_W-1:0] enc_cw;
        logic [CW_W-1:0] mem_d [DEPTH];
        logic [CW_W-1:0] mem_q [DEPTH];

        secded_lane_enc u_enc (
            .data_in (wdata[g*BYTE_W +: BYTE_W]),
            .cw_out  (enc_cw)
        );

        secded_lane_dec u_dec (
            .cw_in    (mem_q[addr]),
            .data_out (dec_data[g]),
            .corr     (dec_corr[g]),
            .unc      (dec_unc[g])
        );

        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = mem_q[i];
                if (do_write && lane_en[g] && addr == i[ADDR_W-1:0])
                    mem_d[i] = enc_cw;
                if (inj_en && int'(inj_lane) == g && inj_addr == i[ADDR_W-1:0])
                    mem_d[i] = mem_d[i] ^ inj_mask;
            end
        end

        always_ff @(posedge clk) begin
            mem_q <= mem_d;
        end

        a_r6_lane_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(dec_corr[g] && dec_unc[g]));
    end

    always_comb begin
        out_d = '0;
        if (do_read) begin
            for (int l = 0; l < LANES; l++) begin
                if (rd_oe && lane_en[l]) begin
                    out_d.rdata[l*BYTE_W +: BYTE_W] = dec_data[l];
                    out_d.drv[l] = 1'b1;
                    out_d.corr   = out_d.corr | dec_corr[l];
                    out_d.unc    = out_d.unc  | dec_unc[l];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rdata     = out_q.rdata;
    assign rdata_drv = out_q.drv;
    assign err_corr  = out_q.corr;
    assign err_unc   = out_q.unc;

    a_r3_drive_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_drv & ~($past(lane_en) & {2{$past(rd_oe)}})) == 2'b00);

    a_r4_quiet_after_write_or_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) || !$past(sel)) |-> (rdata_drv == 2'b00 && !err_corr && !err_unc));

    a_r4_undriven_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdata_drv[0] -> rdata[7:0] == 8'h00) && (!rdata_drv[1] -> rdata[15:8] == 8'h00));

    a_r8_flags_need_driven_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr || err_unc) |-> rdata_drv != 2'b00);
endmodule

// File: tb/bsd_mem_bench.sv
`timescale 1ns/1ps
module bsd_mem_bench;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr_en = 1'b0, rd_oe = 1'b0, inj_en = 1'b0, inj_lane = 1'b0;
    logic [1:0]    lane_en = 2'b00;
    logic [AW-1:0] addr = '0, inj_addr = '0;
    logic [15:0]   wdata = '0;
    logic [12:0]   inj_mask = '0;
    logic [15:0]   rdata;
    logic [1:0]    rdata_drv;
    logic          err_corr, err_unc;
    int            checks = 0;
    int            failures = 0;

    always #2 clk = ~clk;

    bsd_mem #(.ADDR_W(AW)) u_bsd_mem (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_oe(rd_oe),
        .lane_en(lane_en), .addr(addr), .wdata(wdata), .inj_en(inj_en),
        .inj_lane(inj_lane), .inj_addr(inj_addr), .inj_mask(inj_mask),
        .rdata(rdata), .rdata_drv(rdata_drv), .err_corr(err_corr), .err_unc(err_unc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        sel = 1'b0; wr_en = 1'b0; rd_oe = 1'b0; lane_en = 2'b00; inj_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] en);
        sel = 1'b1; wr_en = 1'b1; rd_oe = 1'b1; lane_en = en; addr = a; wdata = d;
        @(negedge clk);
        go_idle();
    endtask

    task automatic inject(input logic ln, input logic [AW-1:0] a, input logic [12:0] m);
        inj_en = 1'b1; inj_lane = ln; inj_addr = a; inj_mask = m;
        @(negedge clk);
        go_idle();
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic oe,
                      input logic [1:0] en, input logic [15:0] exp_d,
                      input logic exp_c, input logic exp_u);
        logic [1:0]  xdrv;
        logic [15:0] xd;
        sel = 1'b1; wr_en = 1'b0; rd_oe = oe; lane_en = en; addr = a;
        @(negedge clk);
        xdrv = oe ? en : 2'b00;
        xd   = exp_d & {{8{xdrv[1]}}, {8{xdrv[0]}}};
        chk({req, " drv"}, {30'd0, rdata_drv}, {30'd0, xdrv});
        chk({req, " flags"}, {30'd0, err_corr, err_unc}, {30'd0, exp_c, exp_u});
        if (!exp_u) chk({req, " data"}, {16'd0, rdata}, {16'd0, xd});
        go_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        chk("R4 reset", {14'd0, rdata_drv, rdata}, 32'd0);
        chk("R4 reset flags", {30'd0, err_corr, err_unc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill and read every word
        for (int a = 0; a < (1 << AW); a++)
            wr(a[AW-1:0], 16'(a * 16'h1357) ^ 16'hA5C3, 2'b11);
        for (int a = 0; a < (1 << AW); a++)
            rd("R1", a[AW-1:0], 1'b1, 2'b11, 16'(a * 16'h1357) ^ 16'hA5C3, 1'b0, 1'b0);

        // R3 / R4: every output-enable and lane-enable combination
        for (int oe = 0; oe < 2; oe++)
            for (int en = 0; en < 4; en++)
                rd("R3", 4'd3, oe[0], en[1:0], 16'(3 * 16'h1357) ^ 16'hA5C3, 1'b0, 1'b0);

        // R4: deselected cycle and write cycle show nothing
        sel = 1'b0; rd_oe = 1'b1; lane_en = 2'b11; addr = 4'd3;
        @(negedge clk);
        chk("R4 deselect", {14'd0, rdata_drv, rdata}, 32'd0);
        go_idle();
        wr(4'd2, 16'h0F0F, 2'b11);
        chk("R4 write", {12'd0, rdata_drv, err_corr, err_unc, rdata}, 32'd0);

        // R2: lane-selective writes
        wr(4'd5, 16'h1234, 2'b11);
        wr(4'd5, 16'h77AB, 2'b01);
        rd("R2 low only", 4'd5, 1'b1, 2'b11, 16'h12AB, 1'b0, 1'b0);
        wr(4'd5, 16'hCDFF, 2'b10);
        rd("R2 high only", 4'd5, 1'b1, 2'b11, 16'hCDAB, 1'b0, 1'b0);
        wr(4'd5, 16'hFFFF, 2'b00);
        rd("R2 no lane", 4'd5, 1'b1, 2'b11, 16'hCDAB, 1'b0, 1'b0);
        // R2: fault in untouched lane survives a write to the other lane
        wr(4'd9, 16'h5A3C, 2'b11);
        inject(1'b1, 4'd9, 13'h0040);
        wr(4'd9, 16'h00E1, 2'b01);
        rd("R2 keep fault", 4'd9, 1'b1, 2'b11, 16'h5AE1, 1'b1, 1'b0);
        // R9: rewriting the faulty lane clears the fault
        wr(4'd9, 16'h6600, 2'b10);
        rd("R9 rewrite", 4'd9, 1'b1, 2'b11, 16'h66E1, 1'b0, 1'b0);

        // R5: every single-bit fault in each lane
        for (int ln = 0; ln < 2; ln++)
            for (int b = 0; b < 13; b++) begin
                wr(4'd7, 16'(b * 16'h0B1D) ^ 16'h96E7, 2'b11);
                inject(ln[0], 4'd7, 13'(1 << b));
                rd("R5", 4'd7, 1'b1, 2'b11, 16'(b * 16'h0B1D) ^ 16'h96E7, 1'b1, 1'b0);
            end

        // R6: every pair of faulty bits in each lane
        for (int ln = 0; ln < 2; ln++)
            for (int i = 0; i < 13; i++)
                for (int j = i + 1; j < 13; j++) begin
                    wr(4'd11, 16'((i * 13 + j) * 16'h0325), 2'b11);
                    inject(ln[0], 4'd11, 13'((1 << i) | (1 << j)));
                    rd("R6", 4'd11, 1'b1, 2'b11, 16'h0000, 1'b0, 1'b1);
                end

        // R7: single fault low lane, double fault high lane
        wr(4'd12, 16'hBEEF, 2'b11);
        inject(1'b0, 4'd12, 13'h0004);
        inject(1'b1, 4'd12, 13'h0101);
        rd("R7", 4'd12, 1'b1, 2'b11, 16'hBEEF, 1'b1, 1'b1);
        // R8: flags follow only the presented lanes
        rd("R8 low lane", 4'd12, 1'b1, 2'b01, 16'hBEEF, 1'b1, 1'b0);
        rd("R8 high lane", 4'd12, 1'b1, 2'b10, 16'h0000, 1'b0, 1'b1);
        rd("R8 oe off", 4'd12, 1'b0, 2'b11, 16'h0000, 1'b0, 1'b0);

        // R9: persistence and cancellation
        wr(4'd13, 16'h4C2D, 2'b11);
        inject(1'b0, 4'd13, 13'h0800);
        rd("R9 persist a", 4'd13, 1'b1, 2'b11, 16'h4C2D, 1'b1, 1'b0);
        rd("R9 persist b", 4'd13, 1'b1, 2'b11, 16'h4C2D, 1'b1, 1'b0);
        inject(1'b0, 4'd13, 13'h0800);
        rd("R9 cancel", 4'd13, 1'b1, 2'b11, 16'h4C2D, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule